// File: doc/BRIEF.md
# Raster Scan Timing Generator

This block turns a master clock into the beam position of a fixed-format raster frame. Four master cycles form one dot and 340 dots form one line. The frame holds 262 lines. The block counts the dot and the line and decodes from them every timing window that other logic needs. It does not render pixels, run transfers or execute code; it only tells an interrupt controller, a counter-latch block and a transfer engine where the beam is.

Line 0 is hidden. The lines after it are displayed up to a last display line, which the `tall_mode` input selects: line 224 when it is low, line 239 when it is high. Vertical blank covers the lines after the last display line, wraps around the frame boundary and ends with line 0. Within a line, the first 22 dots and the last 62 dots are horizontal blank.

On every line, blank or not, a memory-refresh window stalls the processor and the transfer engines for 40 master cycles. A start-of-line-transfer strobe marks the point where blank begins after the visible dots. A controller-busy flag covers the first lines of vertical blank. A field bit flips at every new frame. A packed status byte gathers the blank and busy flags at fixed bit positions for a register read path.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `dot_x` and `line_y` become 0, `field` becomes 0 and `ctrl_busy` becomes 0.
- R2: `dot_x` advances once every 4 master cycles and wraps from 339 to 0. That wrap advances `line_y`, which wraps from 261 to 0.
- R3: `hblank` is high when `dot_x` < 22 or `dot_x` >= 278. `disp_active` is high only for dots 22..277 on lines that are not in vertical blank.
- R4: `vblank` is high on line 0 and on every line after the last display line. The last display line is 224 when `tall_mode` is 0 and 239 when `tall_mode` is 1.
- R5: `refresh_stall` is high for master cycles 512..551 of every line, counted from the first cycle of dot 0. That is from the first cycle of dot 128 to the last cycle of dot 137, on blank lines as well.
- R6: `dma_start` is a one-cycle pulse in the first master cycle of dot 278. It fires on lines 0 through the last display line and on no other line.
- R7: `ctrl_busy` rises at the start of the first vertical-blank line. It stays high through the two lines that follow and falls at the start of the fourth vertical-blank line.
- R8: `field` inverts each time `line_y` wraps to 0.
- R9: `status` is {vblank in bit 7, hblank in bit 6, zeros in bits 5..1, ctrl_busy in bit 0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tall_mode | input | 1 | 0: last display line 224, 1: last display line 239 |
| dot_x | output | 9 | Dot position within the line, 0..339 |
| line_y | output | 9 | Line number within the frame, 0..261 |
| disp_active | output | 1 | Beam is on a displayed dot of a displayed line |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| refresh_stall | output | 1 | Refresh window; stalls the processor and the transfer engines |
| dma_start | output | 1 | One-cycle strobe at the start of blank after the visible dots |
| ctrl_busy | output | 1 | Controller-read window at the start of vertical blank |
| field | output | 1 | Frame parity, inverts each frame |
| status | output | 8 | Packed flags: bit 7 vblank, bit 6 hblank, bit 0 ctrl_busy |

## Verification
Two pairs of functions land on the same clock edge. The rise of `vblank` on the first blank line is also the edge where the busy sequencer loads, and the rise of `hblank` at dot 278 is also the cycle of the `dma_start` pulse. The bench runs a copy with one master cycle per dot through whole frames in both display heights. It samples the first cycle of the first blank line and requires `vblank` and `ctrl_busy` high together there. It also requires the strobe at dot 278 on the last display line and no strobe one line later.

// File: rtl/raster_pkg.sv
package raster_pkg;

   // bit positions of the packed status byte, decoded by the register read path
   localparam int unsigned STAT_VBLANK_BIT = 7;
   localparam int unsigned STAT_HBLANK_BIT = 6;
   localparam int unsigned STAT_BUSY_BIT   = 0;

   typedef struct packed {
      logic       vblank;
      logic       hblank;
      logic [4:0] zero;
      logic       busy;
   } raster_status_t;

   typedef enum logic {
      BUSY_IDLE = 1'b0,
      BUSY_HOLD = 1'b1
   } busy_state_e;

   function automatic int unsigned last_display_line(input logic tall,
                                                      input int unsigned short_last,
                                                      input int unsigned tall_last);
      return tall ? tall_last : short_last;
   endfunction

endpackage

// File: rtl/raster_dot_counter.sv
module raster_dot_counter #(
   parameter int unsigned MCLK_PER_DOT  = 4,
   parameter int unsigned DOTS_PER_LINE = 340,
   parameter int unsigned DOT_W         = $clog2(DOTS_PER_LINE),
   parameter int unsigned PH_W          = (MCLK_PER_DOT > 1) ? $clog2(MCLK_PER_DOT) : 1
) (
   input  logic             clk,
   input  logic             rst,
   output logic [DOT_W-1:0] dot,
   output logic [PH_W-1:0]  phase,
   output logic             line_adv
);

   localparam logic [DOT_W-1:0] LAST_DOT = DOT_W'(DOTS_PER_LINE - 1);

   logic dot_adv;

   generate
      if (MCLK_PER_DOT > 1) begin : g_divided
         localparam logic [PH_W-1:0] LAST_PH = PH_W'(MCLK_PER_DOT - 1);
         logic [PH_W-1:0] ph_q;

         always_ff @(posedge clk) begin
            if (rst)
               ph_q <= '0;
            else if (ph_q == LAST_PH)
               ph_q <= '0;
            else
               ph_q <= ph_q + 1'b1;
         end

         assign phase   = ph_q;
         assign dot_adv = (ph_q == LAST_PH);
      end else begin : g_direct
         assign phase   = '0;
         assign dot_adv = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         dot <= '0;
      else if (dot_adv) begin
         if (dot == LAST_DOT)
            dot <= '0;
         else
            dot <= dot + 1'b1;
      end
   end

   assign line_adv = dot_adv && (dot == LAST_DOT);

endmodule

// File: rtl/raster_line_counter.sv
module raster_line_counter #(
   parameter int unsigned LINES_PER_FRAME = 262,
   parameter int unsigned LINE_W          = $clog2(LINES_PER_FRAME)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              line_adv,
   output logic [LINE_W-1:0] line,
   output logic [LINE_W-1:0] next_line,
   output logic              field
);

   localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES_PER_FRAME - 1);

   always_comb begin
      if (line == LAST_LINE)
         next_line = '0;
      else
         next_line = line + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         line  <= '0;
         field <= 1'b0;
      end else if (line_adv) begin
         line <= next_line;
         if (next_line == '0)
            field <= ~field;
      end
   end

endmodule

// File: rtl/raster_window_decode.sv
module raster_window_decode #(
   parameter int unsigned MCLK_PER_DOT  = 4,
   parameter int unsigned DOTS_PER_LINE = 340,
   parameter int unsigned HBL_LEAD      = 22,
   parameter int unsigned ACTIVE_DOTS   = 256,
   parameter int unsigned REFRESH_DOT   = 128,
   parameter int unsigned REFRESH_MCLK  = 40,
   parameter int unsigned DOT_W         = 9,
   parameter int unsigned PH_W          = 2,
   parameter int unsigned LINE_W        = 9
) (
   input  logic [DOT_W-1:0]  dot,
   input  logic [PH_W-1:0]   phase,
   input  logic [LINE_W-1:0] line,
   input  logic [LINE_W-1:0] last_line,
   output logic              hblank,
   output logic              vblank,
   output logic              disp_active,
   output logic              refresh_stall,
   output logic              dma_start
);

   localparam int unsigned LINE_MCLK  = DOTS_PER_LINE * MCLK_PER_DOT;
   localparam int unsigned POS_W      = $clog2(LINE_MCLK + 1);
   localparam int unsigned RFSH_FIRST = REFRESH_DOT * MCLK_PER_DOT;
   localparam int unsigned RFSH_END   = RFSH_FIRST + REFRESH_MCLK;
   localparam int unsigned TAIL_DOT   = HBL_LEAD + ACTIVE_DOTS;

   logic [POS_W-1:0] line_pos;

   // master-cycle offset inside the line
   always_comb begin
      line_pos = POS_W'(dot) * POS_W'(MCLK_PER_DOT) + POS_W'(phase);
   end

   always_comb begin
      hblank        = (dot < DOT_W'(HBL_LEAD)) || (dot >= DOT_W'(TAIL_DOT));
      vblank        = (line == '0) || (line > last_line);
      disp_active   = !hblank && !vblank;
      refresh_stall = (line_pos >= POS_W'(RFSH_FIRST)) && (line_pos < POS_W'(RFSH_END));
      dma_start     = (dot == DOT_W'(TAIL_DOT)) && (phase == '0) && (line <= last_line);
   end

endmodule

// File: rtl/raster_busy_seq.sv
module raster_busy_seq
   import raster_pkg::*;
#(
   parameter int unsigned BUSY_LINES = 3,
   parameter int unsigned LINE_W     = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              line_adv,
   input  logic [LINE_W-1:0] next_line,
   input  logic [LINE_W-1:0] last_line,
   output logic              busy
);

   localparam int unsigned CNT_W = $clog2(BUSY_LINES + 1);

   busy_state_e      state;
   logic [CNT_W-1:0] left;
   logic             enter_vbl;

   assign enter_vbl = line_adv && (next_line == last_line + 1'b1);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= BUSY_IDLE;
         left  <= '0;
      end else if (enter_vbl) begin
         state <= BUSY_HOLD;
         left  <= CNT_W'(BUSY_LINES - 1);
      end else if (line_adv && state == BUSY_HOLD) begin
         if (left == '0)
            state <= BUSY_IDLE;
         else
            left <= left - 1'b1;
      end
   end

   assign busy = (state == BUSY_HOLD);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import raster_pkg::*;
#(
   parameter int unsigned MCLK_PER_DOT    = 4,
   parameter int unsigned DOTS_PER_LINE   = 340,
   parameter int unsigned HBL_LEAD        = 22,
   parameter int unsigned ACTIVE_DOTS     = 256,
   parameter int unsigned REFRESH_DOT     = 128,
   parameter int unsigned REFRESH_MCLK    = 40,
   parameter int unsigned LINES_PER_FRAME = 262,
   parameter int unsigned SHORT_LAST      = 224,
   parameter int unsigned TALL_LAST       = 239,
   parameter int unsigned BUSY_LINES      = 3
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tall_mode,
   output logic [8:0] dot_x,
   output logic [8:0] line_y,
   output logic       disp_active,
   output logic       hblank,
   output logic       vblank,
   output logic       refresh_stall,
   output logic       dma_start,
   output logic       ctrl_busy,
   output logic       field,
   output logic [7:0] status
);

   localparam int unsigned DOT_W  = $clog2(DOTS_PER_LINE);
   localparam int unsigned LINE_W = $clog2(LINES_PER_FRAME);
   localparam int unsigned PH_W   = (MCLK_PER_DOT > 1) ? $clog2(MCLK_PER_DOT) : 1;

   // elaboration-time parameter checks
   generate
      if (MCLK_PER_DOT < 1) begin : g_bad_div
         $error("MCLK_PER_DOT must be at least 1");
      end
      if (DOT_W > 9 || LINE_W > 9) begin : g_bad_width
         $error("dot or line count exceeds the 9-bit port width");
      end
      if (HBL_LEAD + ACTIVE_DOTS >= DOTS_PER_LINE) begin : g_bad_hline
         $error("visible dots must end before the line does");
      end
      if ((REFRESH_DOT * MCLK_PER_DOT) + REFRESH_MCLK > DOTS_PER_LINE * MCLK_PER_DOT) begin : g_bad_rfsh
         $error("refresh window must fit in one line");
      end
      if (SHORT_LAST > TALL_LAST || TALL_LAST + BUSY_LINES >= LINES_PER_FRAME) begin : g_bad_vframe
         $error("display heights or busy window do not fit the frame");
      end
      if (BUSY_LINES < 1) begin : g_bad_busy
         $error("BUSY_LINES must be at least 1");
      end
   endgenerate

   logic [DOT_W-1:0]  dot;
   logic [PH_W-1:0]   phase;
   logic              line_adv;
   logic [LINE_W-1:0] line;
   logic [LINE_W-1:0] next_line;
   logic [LINE_W-1:0] last_line;
   raster_status_t    stat;

   assign last_line = LINE_W'(last_display_line(tall_mode, SHORT_LAST, TALL_LAST));

   raster_dot_counter #(
      .MCLK_PER_DOT  (MCLK_PER_DOT),
      .DOTS_PER_LINE (DOTS_PER_LINE),
      .DOT_W         (DOT_W),
      .PH_W          (PH_W)
   ) u_dot (
      .clk      (clk),
      .rst      (rst),
      .dot      (dot),
      .phase    (phase),
      .line_adv (line_adv)
   );

   raster_line_counter #(
      .LINES_PER_FRAME (LINES_PER_FRAME),
      .LINE_W          (LINE_W)
   ) u_line (
      .clk       (clk),
      .rst       (rst),
      .line_adv  (line_adv),
      .line      (line),
      .next_line (next_line),
      .field     (field)
   );

   raster_window_decode #(
      .MCLK_PER_DOT  (MCLK_PER_DOT),
      .DOTS_PER_LINE (DOTS_PER_LINE),
      .HBL_LEAD      (HBL_LEAD),
      .ACTIVE_DOTS   (ACTIVE_DOTS),
      .REFRESH_DOT   (REFRESH_DOT),
      .REFRESH_MCLK  (REFRESH_MCLK),
      .DOT_W         (DOT_W),
      .PH_W          (PH_W),
      .LINE_W        (LINE_W)
   ) u_win (
      .dot           (dot),
      .phase         (phase),
      .line          (line),
      .last_line     (last_line),
      .hblank        (hblank),
      .vblank        (vblank),
      .disp_active   (disp_active),
      .refresh_stall (refresh_stall),
      .dma_start     (dma_start)
   );

   raster_busy_seq #(
      .BUSY_LINES (BUSY_LINES),
      .LINE_W     (LINE_W)
   ) u_busy (
      .clk       (clk),
      .rst       (rst),
      .line_adv  (line_adv),
      .next_line (next_line),
      .last_line (last_line),
      .busy      (ctrl_busy)
   );

   always_comb begin
      stat        = '0;
      stat.vblank = vblank;
      stat.hblank = hblank;
      stat.busy   = ctrl_busy;
   end

   assign status = stat;
   assign dot_x  = 9'(dot);
   assign line_y = 9'(line);

endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
   parameter int unsigned DOTS_PER_LINE   = 340,
   parameter int unsigned LINES_PER_FRAME = 262,
   parameter int unsigned REFRESH_DOT     = 128
) (
   input logic       clk,
   input logic       rst,
   input logic [8:0] dot_x,
   input logic [8:0] line_y,
   input logic       disp_active,
   input logic       hblank,
   input logic       vblank,
   input logic       refresh_stall,
   input logic       dma_start,
   input logic       ctrl_busy,
   input logic       field,
   input logic [7:0] status
);

   localparam logic [8:0] LAST_DOT  = 9'(DOTS_PER_LINE - 1);
   localparam logic [8:0] LAST_LINE = 9'(LINES_PER_FRAME - 1);

   // R2: the dot moves by one or wraps from the last dot
   assert_dot_step_R2: assert property (@(posedge clk) disable iff (rst)
      !$stable(dot_x) |-> (dot_x == $past(dot_x) + 9'd1) ||
                          (dot_x == 9'd0 && $past(dot_x) == LAST_DOT));

   // R2: a dot wrap moves the line by one or wraps the frame
   assert_line_step_R2: assert property (@(posedge clk) disable iff (rst)
      (dot_x == 9'd0 && $past(dot_x) == LAST_DOT) |->
         (line_y == $past(line_y) + 9'd1) ||
         (line_y == 9'd0 && $past(line_y) == LAST_LINE));

   // R3: displayed dots are never inside a blank
   assert_active_excl_R3: assert property (@(posedge clk) disable iff (rst)
      disp_active |-> !hblank && !vblank);

   // R4: the hidden line is always blank
   assert_line0_blank_R4: assert property (@(posedge clk) disable iff (rst)
      line_y == 9'd0 |-> vblank);

   // R5: the refresh window opens on its fixed dot
   assert_refresh_open_R5: assert property (@(posedge clk) disable iff (rst)
      $rose(refresh_stall) |-> dot_x == 9'(REFRESH_DOT));

   // R6: the transfer strobe lasts one cycle and sits in horizontal blank
   assert_dma_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      dma_start |=> !dma_start);
   assert_dma_in_hblank_R6: assert property (@(posedge clk) disable iff (rst)
      dma_start |-> hblank && !vblank || dma_start && line_y == 9'd0);

   // R7: busy only rises inside vertical blank
   assert_busy_in_vblank_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(ctrl_busy) |-> vblank);

   // R8: the field flips on every frame wrap
   assert_field_flip_R8: assert property (@(posedge clk) disable iff (rst)
      (line_y == 9'd0 && $past(line_y) == LAST_LINE) |-> field != $past(field));

   // R9: the status byte carries the flags at their fixed positions
   assert_status_pack_R9: assert property (@(posedge clk) disable iff (rst)
      status == {vblank, hblank, 5'b00000, ctrl_busy});

endmodule

bind raster_timing_gen raster_timing_gen_chk #(
   .DOTS_PER_LINE   (DOTS_PER_LINE),
   .LINES_PER_FRAME (LINES_PER_FRAME),
   .REFRESH_DOT     (REFRESH_DOT)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .dot_x         (dot_x),
   .line_y        (line_y),
   .disp_active   (disp_active),
   .hblank        (hblank),
   .vblank        (vblank),
   .refresh_stall (refresh_stall),
   .dma_start     (dma_start),
   .ctrl_busy     (ctrl_busy),
   .field         (field),
   .status        (status)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 199000;
   localparam int A_LINE_MC  = 340 * 4;
   localparam int B_LINE     = 340;
   localparam int N_VEC      = 14;

   // vector: line[27:19] dot[18:10] phase[9:8] unused[7:5] hbl vbl act stall dma
   localparam logic [27:0] VEC [N_VEC] = '{
      {9'd0,   9'd128, 2'd0, 3'd0, 5'b01010},
      {9'd0,   9'd278, 2'd0, 3'd0, 5'b11001},
      {9'd1,   9'd0,   2'd0, 3'd0, 5'b10000},
      {9'd1,   9'd21,  2'd3, 3'd0, 5'b10000},
      {9'd1,   9'd22,  2'd0, 3'd0, 5'b00100},
      {9'd1,   9'd127, 2'd3, 3'd0, 5'b00100},
      {9'd1,   9'd128, 2'd0, 3'd0, 5'b00110},
      {9'd1,   9'd137, 2'd3, 3'd0, 5'b00110},
      {9'd1,   9'd138, 2'd0, 3'd0, 5'b00100},
      {9'd1,   9'd277, 2'd3, 3'd0, 5'b00100},
      {9'd1,   9'd278, 2'd0, 3'd0, 5'b10001},
      {9'd1,   9'd278, 2'd1, 3'd0, 5'b10000},
      {9'd1,   9'd339, 2'd3, 3'd0, 5'b10000},
      {9'd2,   9'd0,   2'd0, 3'd0, 5'b10000}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic a_tall = 1'b0;
   logic b_tall = 1'b0;
   int   cyc;
   int   n_chk = 0;
   int   n_fail = 0;

   logic [8:0] a_dot, a_line, b_dot, b_line;
   logic       a_act, a_hbl, a_vbl, a_st, a_dma, a_busy, a_fld;
   logic       b_act, b_hbl, b_vbl, b_st, b_dma, b_busy, b_fld;
   logic [7:0] a_stat, b_stat;

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   raster_timing_gen u_raster_timing_gen (
      .clk (clk), .rst (rst), .tall_mode (a_tall),
      .dot_x (a_dot), .line_y (a_line), .disp_active (a_act),
      .hblank (a_hbl), .vblank (a_vbl), .refresh_stall (a_st),
      .dma_start (a_dma), .ctrl_busy (a_busy), .field (a_fld), .status (a_stat)
   );

   // one master cycle per dot, so whole frames fit in the run
   raster_timing_gen #(.MCLK_PER_DOT(1), .REFRESH_MCLK(10)) u_raster_timing_gen_fast (
      .clk (clk), .rst (rst), .tall_mode (b_tall),
      .dot_x (b_dot), .line_y (b_line), .disp_active (b_act),
      .hblank (b_hbl), .vblank (b_vbl), .refresh_stall (b_st),
      .dma_start (b_dma), .ctrl_busy (b_busy), .field (b_fld), .status (b_stat)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got %0h expected %0h (cycle %0d)", req, got, exp, cyc);
      end
   endtask

   task automatic wait_cyc(input int target);
      while (cyc != target) @(negedge clk);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got %0d expected completion", cyc);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset dot/line", {a_dot, a_line}, 32'd0);
      chk("R1 reset field/busy/vblank", {a_fld, a_busy, a_vbl, b_fld, b_busy}, 32'b00100);
      rst = 1'b0;

      // R2 R3 R4 R5 R6: dot-level windows at four master cycles per dot
      for (int i = 0; i < N_VEC; i++) begin
         wait_cyc(int'(VEC[i][27:19]) * A_LINE_MC + int'(VEC[i][18:10]) * 4 + int'(VEC[i][9:8]));
         chk($sformatf("R2 R3 R4 R5 R6 vector %0d", i),
             {a_line, a_dot, a_hbl, a_vbl, a_act, a_st, a_dma},
             {VEC[i][27:19], VEC[i][18:10], VEC[i][4:0]});
      end

      // short frame on the fast copy
      wait_cyc(224 * B_LINE + 278);
      chk("R6 strobe on last display line", {b_vbl, b_dma, b_hbl}, 32'b011);
      wait_cyc(225 * B_LINE);
      chk("R4 R7 first blank line sets busy with vblank", {b_vbl, b_busy, b_act}, 32'b110);
      wait_cyc(225 * B_LINE + 278);
      chk("R6 no strobe in vertical blank", {b_dma, b_hbl}, 32'b01);
      wait_cyc(227 * B_LINE + 339);
      chk("R7 busy held on third blank line", b_busy, 32'd1);
      wait_cyc(228 * B_LINE);
      chk("R7 busy cleared at fourth blank line", b_busy, 32'd0);
      wait_cyc(261 * B_LINE + 339);
      chk("R2 last dot of frame", {b_line, b_dot, b_fld}, {9'd261, 9'd339, 1'b0});
      wait_cyc(262 * B_LINE);
      chk("R2 R8 frame wrap toggles field", {b_line, b_dot, b_fld, b_vbl}, {9'd0, 9'd0, 1'b1, 1'b1});
      chk("R9 status packing", b_stat, 32'hC0);

      // reset again in tall mode
      rst    = 1'b1;
      b_tall = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset clears field", {b_fld, b_line, b_dot}, 32'd0);
      rst = 1'b0;

      wait_cyc(224 * B_LINE + 100);
      chk("R4 tall mode line 224 displayed", {b_vbl, b_act}, 32'b01);
      wait_cyc(239 * B_LINE + 278);
      chk("R6 strobe on last tall line", {b_vbl, b_dma}, 32'b01);
      wait_cyc(240 * B_LINE);
      chk("R4 R7 tall blank start", {b_vbl, b_busy, b_stat}, {1'b1, 1'b1, 8'hC1});
      wait_cyc(242 * B_LINE + 339);
      chk("R7 tall busy held", b_busy, 32'd1);
      wait_cyc(243 * B_LINE);
      chk("R7 tall busy cleared", b_busy, 32'd0);
      wait_cyc(243 * B_LINE + 128);
      chk("R5 refresh on blank line", {b_st, b_vbl}, 32'b11);

      summary();
      $finish;
   end

endmodule